// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a register-mapped watchdog with 16-bit registers. Software writes a timeout code and then sets a run bit. From that point a countdown, clocked by an external half-second tick enable, runs toward zero and cannot be stopped. To restart the countdown, software writes two fixed key words in order to the service register. If the countdown reaches zero, the block raises one of two outputs. One is an internal reset request. The other is an active-low external reset pin. A write-once routing bit picks between them. An optional interrupt fires in the same cycle as the expiry.

A second, fixed 16-second guard counter runs from system reset. Software cannot refresh it, only switch it off, and once off it stays off. If this guard is still enabled when it runs out, it raises the internal reset request. The tick prescaler and the chip reset controller sit outside the block.

Top module: `svc_wdog`

## Requirements
- R1: After reset, control (0x0) reads 0x0000, guard enable (misc 0x8 bit 0) reads 1, `int_reset_req` and `wdog_irq` are low and `ext_reset_n` is high.
- R2: Writing control with bit 2 set and timeout code T in bits [15:8] starts the countdown. Expiry happens on exactly the T+1-th tick (half a second per tick), and not earlier.
- R3: The run bit (control bit 2) and the routing bit (control bit 5) can only be set. Writing them as 0 leaves them set, and the countdown keeps running.
- R4: Writing 0x5555 and then 0xAAAA to the service register (0x2) reloads the countdown with T+1 ticks.
- R5: A write of 0xAAAA that is not directly preceded by 0x5555 does not reload the countdown. Any other service write between the two keys cancels the sequence.
- R6: On expiry, `int_reset_req` rises if control bit 5 is clear. If bit 5 is set, `ext_reset_n` falls instead.
- R7: With interrupt control (0x6) bit 15 set, `wdog_irq` rises in the same cycle as the expiry. With bit 15 clear, `wdog_irq` stays low.
- R8: The guard counter raises `int_reset_req` on the 32nd tick after reset, unless misc bit 0 was cleared before then. Writing 1 to that bit afterwards does not turn the guard back on.
- R9: Status (0x4) reads bit 0 = main countdown expired and bit 1 = guard expired. Both bits are sticky until reset.
- R10: The timeout code stays writable while the countdown runs. A new code takes effect at the next completed key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| tick_en | input | 1 | Half-second tick enable, one clock wide |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from address) |
| int_reset_req | output | 1 | Internal reset request |
| ext_reset_n | output | 1 | External reset, active low |
| wdog_irq | output | 1 | Expiry interrupt |

## Verification
The bench counts ticks across the expiry boundary, so a design that is off by one tick in its T+1 arithmetic trips early or late and is caught. It sends a lone second key and an interrupted key pair. A checker that reloads on either of these would miss its expiry. It writes 0 to the run and routing bits, and a design that lets them clear would stop or reroute the reset. It writes 1 to the guard bit after clearing it, and a design that re-arms the guard would fire a spurious internal reset.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;
  parameter int REG_W   = 16;
  parameter int ADDR_W  = 4;
  parameter int TCODE_W = 8;
  parameter int CNT_W   = TCODE_W + 1;
  parameter int PD_TICKS = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_IRQC = 4'h6;
  localparam logic [ADDR_W-1:0] A_MISC = 4'h8;

  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  localparam int BIT_RUN = 2;
  localparam int BIT_EXT = 5;

  // Timeout code T covers T+1 half-second ticks.
  function automatic logic [CNT_W-1:0] code_to_ticks(input logic [TCODE_W-1:0] code);
    return {1'b0, code} + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int W = 9,
  parameter int RST_CNT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         expired
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= W'(RST_CNT);
      expired <= 1'b0;
    end else if (!expired) begin
      if (load) begin
        cnt <= load_val;
      end else if (dec && cnt != '0) begin
        cnt <= cnt - ONE;
        if (cnt == ONE) expired <= 1'b1;
      end
    end
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n) expired |=> expired);
  p_no_climb_r2: assert property (@(posedge clk) disable iff (!rst_n) !load |=> cnt <= $past(cnt));
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import svc_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_wr,
  input  logic [REG_W-1:0] wdata,
  output logic             refresh
);
  logic armed;

  assign refresh = svc_wr && (wdata == KEY_FIRE) && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (svc_wr) armed <= (wdata == KEY_ARM);
  end

  p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && wdata != KEY_ARM) |=> !armed);
endmodule

// File: rtl/wdog_regbank.sv
module wdog_regbank
  import svc_wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  input  logic               main_exp,
  input  logic               pd_exp,
  output logic [REG_W-1:0]   bus_rdata,
  output logic [TCODE_W-1:0] tcode,
  output logic               run,
  output logic               ext_sel,
  output logic               ien,
  output logic               pd_en,
  output logic               run_set,
  output logic               svc_wr
);
  logic wr_ctrl, wr_irqc, wr_misc;

  assign wr_ctrl = bus_sel && bus_wr && bus_addr == A_CTRL;
  assign wr_irqc = bus_sel && bus_wr && bus_addr == A_IRQC;
  assign wr_misc = bus_sel && bus_wr && bus_addr == A_MISC;
  assign svc_wr  = bus_sel && bus_wr && bus_addr == A_SVC;
  assign run_set = wr_ctrl && bus_wdata[BIT_RUN] && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcode   <= '0;
      run     <= 1'b0;
      ext_sel <= 1'b0;
      ien     <= 1'b0;
      pd_en   <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        tcode <= bus_wdata[REG_W-1 -: TCODE_W];
        if (bus_wdata[BIT_RUN]) run     <= 1'b1;
        if (bus_wdata[BIT_EXT]) ext_sel <= 1'b1;
      end
      if (wr_irqc) ien <= bus_wdata[REG_W-1];
      if (wr_misc && !bus_wdata[0]) pd_en <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[REG_W-1 -: TCODE_W] = tcode;
        bus_rdata[BIT_RUN] = run;
        bus_rdata[BIT_EXT] = ext_sel;
      end
      A_STAT: bus_rdata[1:0] = {pd_exp, main_exp};
      A_IRQC: bus_rdata[REG_W-1] = ien;
      A_MISC: bus_rdata[0] = pd_en;
      default: bus_rdata = '0;
    endcase
  end

  p_run_keep_r3: assert property (@(posedge clk) disable iff (!rst_n) run |=> run);
  p_ext_keep_r3: assert property (@(posedge clk) disable iff (!rst_n) ext_sel |=> ext_sel);
  p_pd_once_r8:  assert property (@(posedge clk) disable iff (!rst_n) !pd_en |=> !pd_en);
endmodule

// File: rtl/svc_wdog.sv
module svc_wdog
  import svc_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              int_reset_req,
  output logic              ext_reset_n,
  output logic              wdog_irq
);
  logic [TCODE_W-1:0] tcode;
  logic run, ext_sel, ien, pd_en, run_set, svc_wr, refresh;
  logic main_exp, pd_exp, main_load;
  logic [CNT_W-1:0] main_val, main_cnt;
  logic [CNT_W-1:0] pd_cnt;

  wdog_regbank u_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .main_exp, .pd_exp, .bus_rdata, .tcode, .run, .ext_sel, .ien,
    .pd_en, .run_set, .svc_wr
  );

  wdog_keyseq u_keys (
    .clk, .rst_n, .svc_wr, .wdata(bus_wdata), .refresh
  );

  assign main_load = run_set || (refresh && run);
  assign main_val  = code_to_ticks(run_set ? bus_wdata[REG_W-1 -: TCODE_W] : tcode);

  wdog_countdown #(.W(CNT_W), .RST_CNT(0)) u_main (
    .clk, .rst_n, .load(main_load), .load_val(main_val),
    .dec(tick_en && run), .cnt(main_cnt), .expired(main_exp)
  );

  wdog_countdown #(.W(CNT_W), .RST_CNT(PD_TICKS)) u_guard (
    .clk, .rst_n, .load(1'b0), .load_val('0),
    .dec(tick_en && pd_en), .cnt(pd_cnt), .expired(pd_exp)
  );

  assign int_reset_req = (main_exp && !ext_sel) || pd_exp;
  assign ext_reset_n   = !(main_exp && ext_sel);
  assign wdog_irq      = main_exp && ien;

  p_irq_with_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && ext_sel) |-> (wdog_irq == !ext_reset_n));
  p_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_exp) |-> run);
  p_ext_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_reset_n |-> ext_sel);
endmodule

// File: tb/svc_wdog_tb.sv
module svc_wdog_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic int_reset_req, ext_reset_n, wdog_irq;
  int checks = 0, failures = 0, cycles = 0;

  typedef struct { string req; int kind; logic [15:0] exp; } item_t;
  item_t sb_q[$];
  event sample_ev;

  always #4 clk = ~clk;

  svc_wdog dut_i (.*);

  // Monitor: pops expected items and compares against the live outputs.
  initial forever begin
    @(sample_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = sb_q.pop_front();
      case (it.kind)
        0: got = bus_rdata;
        1: got = {15'b0, int_reset_req};
        2: got = {15'b0, ext_reset_n};
        default: got = {15'b0, wdog_irq};
      endcase
      checks++;
      if (got !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic push(input string req, input int kind, input logic [15:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic outs(input string req, input bit irq_e, input bit ext_e, input bit irq);
    @(negedge clk);
    push(req, 1, {15'b0, irq_e});
    push(req, 2, {15'b0, ext_e});
    push(req, 3, {15'b0, irq});
    #1 ->sample_ev;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 push(req, 0, exp);
    ->sample_ev;
    @(negedge clk) bus_sel = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1;
      @(negedge clk) tick_en = 0;
    end
  endtask

  task automatic do_reset(input bit kill_guard);
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    if (kill_guard) wr(4'h8, 16'h0000);
  endtask

  initial begin
    forever begin
      @(posedge clk) cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    do_reset(0);
    // R1 reset state
    rd("R1", 4'h0, 16'h0000);
    rd("R1", 4'h8, 16'h0001);
    outs("R1", 0, 1, 0);
    // R8 guard fires on tick 32
    ticks(31);
    outs("R8", 0, 1, 0);
    ticks(1);
    outs("R8", 1, 1, 0);
    rd("R9", 4'h4, 16'h0002);

    // R8 guard cleared stays off
    do_reset(0);
    ticks(10);
    wr(4'h8, 16'h0000);
    wr(4'h8, 16'h0001);
    rd("R8", 4'h8, 16'h0000);
    ticks(40);
    outs("R8", 0, 1, 0);

    // R2 / R6 internal route, no interrupt
    wr(4'h0, 16'h0304);
    ticks(3);
    outs("R2", 0, 1, 0);
    ticks(1);
    outs("R2_R6", 1, 1, 0);
    rd("R9", 4'h4, 16'h0001);

    // R3 / R4 / R6 / R7 external route with interrupt
    do_reset(1);
    wr(4'h6, 16'h8000);
    wr(4'h0, 16'h0524);
    rd("R3", 4'h0, 16'h0524);
    wr(4'h0, 16'h0500);
    rd("R3", 4'h0, 16'h0524);
    ticks(4);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    ticks(5);
    outs("R4", 0, 1, 0);
    ticks(1);
    outs("R6_R7", 0, 0, 1);

    // R5 lone second key
    do_reset(1);
    wr(4'h0, 16'h0304);
    ticks(3);
    wr(4'h2, 16'hAAAA);
    ticks(1);
    outs("R5", 1, 1, 0);

    // R5 interrupted sequence
    do_reset(1);
    wr(4'h0, 16'h0304);
    ticks(3);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'h1234);
    wr(4'h2, 16'hAAAA);
    ticks(1);
    outs("R5", 1, 1, 0);

    // R4 good sequence reloads
    do_reset(1);
    wr(4'h0, 16'h0304);
    ticks(3);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    ticks(3);
    outs("R4", 0, 1, 0);
    ticks(1);
    outs("R4", 1, 1, 0);

    // R10 code change applies at next refresh
    do_reset(1);
    wr(4'h0, 16'h0104);
    wr(4'h0, 16'h0904);
    ticks(1);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    ticks(9);
    outs("R10", 0, 1, 0);
    ticks(1);
    outs("R10", 1, 1, 0);
    rd("R10", 4'h0, 16'h0904);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule